// File: doc/BRIEF.md
# Host Keyboard-Controller Byte Mailbox

This block sits between a host processor bus and an embedded keyboard-controller core. Each direction has a one-byte buffer. The host writes bytes into an input buffer, and the core reads them out. The core writes bytes into an output buffer, and the host reads them back. An 8-bit status byte holds the handshake flags. Both sides can read it. The host sees it at the command/status address.

Each flag is set from one side of the mailbox and cleared from the other. A core write to its data register sets output-full. A host read of the data address clears it. A host write at either address sets input-full. A core read of its data register clears it. The host write also records whether the data or the command address was used.

The block drives two event signals. A keyboard interrupt line toward the host is raised by core writes, but only while an enable input is high. A one-cycle pulse toward the core signals a new host byte, and the core uses it as both an interrupt and a wake-up event. The core also owns a system flag and four general-purpose status bits.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset, the input buffer, the output buffer and all eight status bits are 0, and `kbd_irq_o` and `core_ibf_pulse_o` are low.
- R2: A host write (`host_cs_i` and `host_wr_i` high) at either address loads `host_wdata_i` into the input buffer and sets status bit 1 (input-full). In the same cycle it loads status bit 3 with `host_addr_i`, where 1 means command and 0 means data.
- R3: `core_rdata_o` always shows the input buffer. A core data read (`core_data_rd_i`) clears status bit 1 at the next edge, unless a host write happens in the same cycle. In that case input-full stays set.
- R4: A core data write (`core_data_wr_i`) loads `core_wdata_i` into the output buffer and sets status bit 0 (output-full). `host_rdata_o` shows the output buffer when `host_addr_i` is 0 and the status byte when it is 1.
- R5: A host read at address 0 (`host_cs_i` and `host_rd_i` high) clears output-full and `kbd_irq_o` at the next edge. A core data write in the same cycle wins, and output-full stays set. A host read at address 1 changes nothing.
- R6: `kbd_irq_o` goes high the cycle after a core data write made while `irq_en_i` is high. A core write made while `irq_en_i` is low does not raise it. Once high, it stays high until a host data read clears it, and it is never high while output-full is clear.
- R7: `core_ibf_pulse_o` is high for exactly the one cycle after a host write that found input-full clear. A host write while input-full is set overwrites the buffer, keeps input-full set and gives no pulse.
- R8: A core status write (`core_stat_wr_i`) loads `core_wdata_i` bit 2 into status bit 2 and bits 7:4 into status bits 7:4. Status bits 0, 1 and 3 are unaffected.
- R9: Host read and write strobes have no effect while `host_cs_i` is low.
- R10: `core_status_o` always equals the status byte that the host reads at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_cs_i | input | 1 | Host chip select |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | 0 = data, 1 = command/status |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (output buffer or status) |
| core_data_wr_i | input | 1 | Core writes the output buffer |
| core_data_rd_i | input | 1 | Core reads the input buffer |
| core_stat_wr_i | input | 1 | Core writes the status bits it owns |
| core_wdata_i | input | 8 | Core write data |
| core_rdata_o | output | 8 | Input buffer toward the core |
| core_status_o | output | 8 | Status byte toward the core |
| irq_en_i | input | 1 | Enable for the keyboard interrupt |
| kbd_irq_o | output | 1 | Keyboard interrupt request to the host |
| core_ibf_pulse_o | output | 1 | One-cycle new-host-byte interrupt and wake event |

## Verification
The assertions take for granted that the host never raises its read and write strobes in the same cycle. A read-plus-write collision is not defined by the protocol, and the output-full and interrupt properties would then depend on which strobe is honoured. They also rely on the core status write touching only bits 2 and 7:4, so the flag properties see bits 0, 1 and 3 change only through mailbox accesses. The stimulus, both directed and pseudo-random, makes the host read and write mutually exclusive. It leaves every core strobe, the enable and the chip select free to collide with host accesses, so the same-cycle priority rules are exercised.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
  localparam int DW     = 8;
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_SYS = 2;
  localparam int ST_CMD = 3;
  localparam int ST_GLO = 4;
  localparam int GEN_W  = DW - ST_GLO;

  typedef struct packed {
    logic wr;
    logic rd_data;
    logic cmd_sel;
  } host_evt_t;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic stat_wr;
  } core_evt_t;
endpackage

// File: rtl/kbc_host_decode.sv
module kbc_host_decode
  import kbc_mbox_pkg::*;
(
  input  logic      cs_i,
  input  logic      rd_i,
  input  logic      wr_i,
  input  logic      addr_i,
  output host_evt_t evt_o
);
  always_comb begin
    evt_o.wr      = cs_i & wr_i;
    evt_o.rd_data = cs_i & rd_i & ~addr_i;
    evt_o.cmd_sel = addr_i;
  end
endmodule

// File: rtl/kbc_byte_reg.sv
module kbc_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/kbc_status_ctl.sv
module kbc_status_ctl
  import kbc_mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  host_evt_t     host_i,
  input  core_evt_t     core_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          irq_en_i,
  output logic [DW-1:0] status_o,
  output logic          irq_o,
  output logic          pulse_o
);
  logic             obf_q, ibf_q, sys_q, cmd_q;
  logic [GEN_W-1:0] gen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_q   <= 1'b0;
      ibf_q   <= 1'b0;
      sys_q   <= 1'b0;
      cmd_q   <= 1'b0;
      gen_q   <= '0;
      irq_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      // core write wins over a simultaneous host drain
      if (core_i.data_wr)      obf_q <= 1'b1;
      else if (host_i.rd_data) obf_q <= 1'b0;
      // host write wins over a simultaneous core drain
      if (host_i.wr)           ibf_q <= 1'b1;
      else if (core_i.data_rd) ibf_q <= 1'b0;
      if (host_i.wr)           cmd_q <= host_i.cmd_sel;
      if (core_i.stat_wr) begin
        sys_q <= core_wdata_i[ST_SYS];
        gen_q <= core_wdata_i[DW-1:ST_GLO];
      end
      if (core_i.data_wr && irq_en_i) irq_o <= 1'b1;
      else if (host_i.rd_data)        irq_o <= 1'b0;
      pulse_o <= host_i.wr & ~ibf_q;
    end
  end

  always_comb begin
    status_o               = '0;
    status_o[ST_OBF]       = obf_q;
    status_o[ST_IBF]       = ibf_q;
    status_o[ST_SYS]       = sys_q;
    status_o[ST_CMD]       = cmd_q;
    status_o[DW-1:ST_GLO]  = gen_q;
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_cs_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  input  logic          host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          core_data_wr_i,
  input  logic          core_data_rd_i,
  input  logic          core_stat_wr_i,
  input  logic [DW-1:0] core_wdata_i,
  output logic [DW-1:0] core_rdata_o,
  output logic [DW-1:0] core_status_o,
  input  logic          irq_en_i,
  output logic          kbd_irq_o,
  output logic          core_ibf_pulse_o
);
  localparam int NBUF = 2;

  host_evt_t     host_evt;
  core_evt_t     core_evt;
  logic [DW-1:0] status;
  logic [DW-1:0] buf_q [NBUF];
  logic          buf_en [NBUF];
  logic [DW-1:0] buf_d [NBUF];

  kbc_host_decode u_dec (
    .cs_i   (host_cs_i),
    .rd_i   (host_rd_i),
    .wr_i   (host_wr_i),
    .addr_i (host_addr_i),
    .evt_o  (host_evt)
  );

  always_comb begin
    core_evt.data_wr = core_data_wr_i;
    core_evt.data_rd = core_data_rd_i;
    core_evt.stat_wr = core_stat_wr_i;
    // slot 0: host->core, slot 1: core->host
    buf_en[0] = host_evt.wr;
    buf_d[0]  = host_wdata_i;
    buf_en[1] = core_data_wr_i;
    buf_d[1]  = core_wdata_i;
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    kbc_byte_reg #(.W(DW)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (buf_en[g]),
      .d_i    (buf_d[g]),
      .q_o    (buf_q[g])
    );
  end

  kbc_status_ctl u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_i       (host_evt),
    .core_i       (core_evt),
    .core_wdata_i (core_wdata_i),
    .irq_en_i     (irq_en_i),
    .status_o     (status),
    .irq_o        (kbd_irq_o),
    .pulse_o      (core_ibf_pulse_o)
  );

  assign core_rdata_o  = buf_q[0];
  assign core_status_o = status;
  assign host_rdata_o  = host_addr_i ? status : buf_q[1];
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk
  import kbc_mbox_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_cs_i,
  input logic          host_rd_i,
  input logic          host_wr_i,
  input logic          host_addr_i,
  input logic [DW-1:0] host_rdata_o,
  input logic          core_data_wr_i,
  input logic          core_data_rd_i,
  input logic [DW-1:0] core_status_o,
  input logic          irq_en_i,
  input logic          kbd_irq_o,
  input logic          core_ibf_pulse_o
);
  logic hwr, hrd0;
  assign hwr  = host_cs_i & host_wr_i;
  assign hrd0 = host_cs_i & host_rd_i & ~host_addr_i;

  p_ibf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwr |=> core_status_o[ST_IBF]);
  p_ibf_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_data_rd_i && !hwr) |=> !core_status_o[ST_IBF]);
  p_obf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_data_wr_i |=> core_status_o[ST_OBF]);
  p_obf_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hrd0 && !core_data_wr_i) |=> (!core_status_o[ST_OBF] && !kbd_irq_o));
  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kbd_irq_o && !(core_data_wr_i && irq_en_i)) |=> !kbd_irq_o);
  p_irq_obf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_irq_o |-> core_status_o[ST_OBF]);
  p_pulse_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwr && !core_status_o[ST_IBF]) |=> core_ibf_pulse_o);
  p_pulse_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ibf_pulse_o |=> !core_ibf_pulse_o);
  p_mirror_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_addr_i |-> (host_rdata_o == core_status_o));
endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .host_cs_i        (host_cs_i),
  .host_rd_i        (host_rd_i),
  .host_wr_i        (host_wr_i),
  .host_addr_i      (host_addr_i),
  .host_rdata_o     (host_rdata_o),
  .core_data_wr_i   (core_data_wr_i),
  .core_data_rd_i   (core_data_rd_i),
  .core_status_o    (core_status_o),
  .irq_en_i         (irq_en_i),
  .kbd_irq_o        (kbd_irq_o),
  .core_ibf_pulse_o (core_ibf_pulse_o)
);

// File: tb/tb_kbc_mailbox.sv
module tb_kbc_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cs, rd, wr, a, cwr, crd, csw, en;
  logic [7:0] hd, cd;
  logic [7:0] hrd, crdata, cstat;
  logic       irq, pls;

  kbc_mailbox dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_cs_i(cs), .host_rd_i(rd), .host_wr_i(wr), .host_addr_i(a),
    .host_wdata_i(hd), .host_rdata_o(hrd),
    .core_data_wr_i(cwr), .core_data_rd_i(crd), .core_stat_wr_i(csw),
    .core_wdata_i(cd), .core_rdata_o(crdata), .core_status_o(cstat),
    .irq_en_i(en), .kbd_irq_o(irq), .core_ibf_pulse_o(pls)
  );

  int n_chk = 0, n_fail = 0;
  // reference state
  logic       m_obf = 0, m_ibf = 0, m_sys = 0, m_cmd = 0, m_irq = 0, m_pls = 0;
  logic [3:0] m_gen = 0;
  logic [7:0] m_ibuf = 0, m_obuf = 0;

  function automatic logic [7:0] m_stat();
    return {m_gen, m_cmd, m_sys, m_ibf, m_obf};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 host_rdata", hrd, a ? m_stat() : m_obuf);
    chk("R3 core_rdata", crdata, m_ibuf);
    chk("R10 core_status", cstat, m_stat());
    chk("R6 kbd_irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R7 ibf_pulse", {7'd0, pls}, {7'd0, m_pls});
  endtask

  task automatic step(logic i_cs, logic i_rd, logic i_wr, logic i_a, logic [7:0] i_hd,
                      logic i_cwr, logic i_crd, logic i_csw, logic [7:0] i_cd, logic i_en);
    logic hw, hr;
    cs = i_cs; rd = i_rd; wr = i_wr; a = i_a; hd = i_hd;
    cwr = i_cwr; crd = i_crd; csw = i_csw; cd = i_cd; en = i_en;
    #1 compare_all();
    @(posedge clk);
    hw = i_cs & i_wr;
    hr = i_cs & i_rd & ~i_a;
    m_pls = hw & ~m_ibf;
    if (hw) begin m_ibuf = i_hd; m_cmd = i_a; end
    if (hw) m_ibf = 1; else if (i_crd) m_ibf = 0;
    if (i_cwr) m_obuf = i_cd;
    if (i_cwr) m_obf = 1; else if (hr) m_obf = 0;
    if (i_cwr && i_en) m_irq = 1; else if (hr) m_irq = 0;
    if (i_csw) begin m_sys = i_cd[2]; m_gen = i_cd[7:4]; end
    @(negedge clk);
  endtask

  task automatic idle(int n, logic e = 1'b1);
    for (int i = 0; i < n; i++) step(0,0,0,0,8'h00, 0,0,0,8'h00, e);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    {cs, rd, wr, a, cwr, crd, csw, en} = '0;
    hd = 0; cd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", cstat, 8'h00);
    chk("R1 core_rdata", crdata, 8'h00);
    chk("R1 irq_pulse", {6'd0, irq, pls}, 8'h00);
    idle(1);
    // R2 data write then command write overwrite (R7 no second pulse)
    step(1,0,1,0,8'hA5, 0,0,0,8'h00, 1);
    chk("R7 pulse high", {7'd0, pls}, 8'h01);
    chk("R2 ibf set data", cstat & 8'h0A, 8'h02);
    step(1,0,1,1,8'h3C, 0,0,0,8'h00, 1);
    chk("R7 no pulse on overwrite", {7'd0, pls}, 8'h00);
    chk("R2 cmd marker", cstat & 8'h0A, 8'h0A);
    chk("R2 ibuf overwritten", crdata, 8'h3C);
    // R3 core read clears IBF
    step(0,0,0,0,8'h00, 0,1,0,8'h00, 1);
    chk("R3 ibf clear", cstat & 8'h02, 8'h00);
    // R3 host write wins over core read
    step(1,0,1,0,8'h11, 0,1,0,8'h00, 1);
    chk("R3 write wins", cstat & 8'h02, 8'h02);
    step(0,0,0,0,8'h00, 0,1,0,8'h00, 1);
    // R6 disabled core write: OBF but no irq
    step(0,0,0,0,8'h00, 1,0,0,8'h5A, 0);
    chk("R6 no irq when disabled", {7'd0, irq}, 8'h00);
    chk("R4 obf set", cstat & 8'h01, 8'h01);
    // R5 status read has no side effect
    step(1,1,0,1,8'h00, 0,0,0,8'h00, 1);
    chk("R5 status read keeps obf", cstat & 8'h01, 8'h01);
    step(1,1,0,0,8'h00, 0,0,0,8'h00, 1);
    chk("R5 data read clears obf", cstat & 8'h01, 8'h00);
    // R6 enabled write raises irq; R5 collision core write wins
    step(0,0,0,0,8'h00, 1,0,0,8'hC3, 1);
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    step(1,1,0,0,8'h00, 1,0,0,8'h77, 1);
    chk("R5 core write wins", cstat & 8'h01, 8'h01);
    // R9 no chip select
    step(0,1,0,0,8'h00, 0,0,0,8'h00, 1);
    step(0,0,1,1,8'hEE, 0,0,0,8'h00, 1);
    chk("R9 no cs keeps obf/irq", {6'd0, irq, cstat[0]}, 8'h03);
    chk("R9 no cs no write", crdata, 8'h11);
    // R8 core status write
    step(0,0,0,0,8'h00, 0,0,1,8'hFF, 1);
    chk("R8 owned bits", cstat & 8'hF4, 8'hF4);
    chk("R8 flags untouched", cstat & 8'h0B, 8'h01);
    step(0,0,0,0,8'h00, 0,0,1,8'h0B, 1);
    chk("R8 clear owned bits", cstat & 8'hF4, 8'h00);
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic r_rd, r_wr;
      r_wr = ($urandom % 4) == 0;
      r_rd = !r_wr && (($urandom % 3) == 0);
      step(($urandom % 5) != 0, r_rd, r_wr, $urandom % 2, 8'($urandom),
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 8) == 0,
           8'($urandom), ($urandom % 4) != 0);
    end
    idle(2);
    finish_run();
  end
endmodule